// File: doc/BRIEF.md
# Streaming Cubic Polynomial Command Engine

This core evaluates a cubic polynomial over streams of fixed-point samples. It sits idle until it sees a one-cycle start pulse. It then reads single-beat command headers from an AXI4-Stream input. A DATA command carries a transaction ID and a sample count. For it, the core first emits one response beat that echoes the command. It then takes the following burst of samples, packed two signed Q16.16 values per 64-bit beat. Each sample goes through Horner evaluation with the four coefficient inputs, and the results leave on the AXI4-Stream output in the same packing.

An END command stops the run cleanly and raises done. Any framing fault stops the run with a sticky error. The possible faults are a header without TLAST, a burst whose TLAST comes early or late, or an unknown command type. The sticky error records a code and the transaction ID involved. The core does not drain the rest of the input. A new start pulse clears the status and begins another run.

Top module: `poly_stream_core`

## Requirements
- R1: After reset, done, halted, s_tready and m_tvalid are 0 and err_code and err_txid are 0; the core accepts no input until start.
- R2: A header beat is laid out as [7:0] kind, [23:8] transaction ID, [39:24] sample count. With TLAST = 1 and kind 1 (END), the run stops with done = 1, halted = 0 and err_code = 0.
- R3: A header with TLAST = 1 and kind 0 (DATA) produces one output beat before any result. That beat has [7:0] = 0, [23:8] = the transaction ID, [39:24] = the count, zero upper bits, and TLAST = 0 when the count is nonzero.
- R4: Each result is c0 + x·(c1 + x·(c2 + x·c3)) in Q16.16. Every product is taken at full width and then arithmetic-shifted right by 16, and every sum wraps to 32 bits. Lane 0 sits in bits [31:0] and lane 1 in bits [63:32], in both the input and output words.
- R5: Results go out two per beat in sample order, with m_tlast = 1 only on the final result beat. When the count is odd, the upper lane of that final output beat is 0, whatever the input carried there.
- R6: A DATA header with count 0 produces a response beat with TLAST = 1 and no burst. The next input beat is read as a header.
- R7: A header beat with TLAST = 0 stops the run with halted = 1, err_code = 1, err_txid = that header's ID, and done = 1.
- R8: In a burst, TLAST = 1 before the final beat or TLAST = 0 on the final beat stops the run with halted = 1, err_code = 2, and err_txid = the burst's transaction ID. The offending beat produces no output.
- R9: A header with TLAST = 1 and a kind other than 0 or 1 stops the run with halted = 1, err_code = 3 and err_txid = its ID.
- R10: While stopped, s_tready stays 0 and the status holds. A start pulse clears halted, err_code and err_txid and resumes header reading.
- R11: While m_tvalid = 1 and m_tready = 0, no input beat is accepted and the pending output word stays unchanged.
- R12: Any number of DATA commands can be processed back to back within one run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a run |
| coef0 | input | 32 | Constant term, Q16.16 |
| coef1 | input | 32 | Linear coefficient, Q16.16 |
| coef2 | input | 32 | Quadratic coefficient, Q16.16 |
| coef3 | input | 32 | Cubic coefficient, Q16.16 |
| s_tdata | input | 64 | Input stream data |
| s_tvalid | input | 1 | Input stream valid |
| s_tlast | input | 1 | Input stream last beat marker |
| s_tready | output | 1 | Input stream ready |
| m_tdata | output | 64 | Output stream data |
| m_tvalid | output | 1 | Output stream valid |
| m_tlast | output | 1 | Output stream last beat marker |
| m_tready | input | 1 | Output stream ready |
| done | output | 1 | High while the run is stopped after END or an error |
| halted | output | 1 | Sticky error flag |
| err_code | output | 8 | 0 none, 1 header framing, 2 burst framing, 3 unknown kind |
| err_txid | output | 16 | Transaction ID of the faulting command |

## Verification
The bench uses odd sample counts. A core that forwarded the spare lane would show junk in the upper half of the final result beat. It also uses a zero count: a core that waited for a burst, or left TLAST clear on the response, would stall or misframe the next header. Burst TLAST is sent one beat early and also held low on the final beat, checking that the error fires on the right beat with code 2, emits nothing for that beat, and keeps the burst's ID. Backpressure during a burst shows whether input is swallowed while the output is stalled. A second start after a stop shows whether stale status survives the new run.

// File: rtl/poly_pkg.sv
package poly_pkg;

    localparam int SAMPLE_W = 32;
    localparam int FRAC_W   = 16;
    localparam int HDR_W    = 40;

    typedef enum logic [7:0] {
        KIND_DATA = 8'd0,
        KIND_END  = 8'd1
    } cmd_kind_e;

    typedef enum logic [7:0] {
        FAULT_NONE  = 8'd0,
        FAULT_HDR   = 8'd1,
        FAULT_BURST = 8'd2,
        FAULT_KIND  = 8'd3
    } fault_e;

    typedef struct packed {
        logic [15:0] count;
        logic [15:0] txid;
        logic [7:0]  kind;
    } cmd_hdr_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HDR,
        PH_RESP,
        PH_BURST,
        PH_STOP
    } phase_e;

    // Q16.16 product: full-width multiply, arithmetic shift, keep low word
    function automatic logic signed [SAMPLE_W-1:0] qmul(
        input logic signed [SAMPLE_W-1:0] a,
        input logic signed [SAMPLE_W-1:0] b
    );
        logic signed [2*SAMPLE_W-1:0] wa;
        logic signed [2*SAMPLE_W-1:0] wb;
        wa = a;
        wb = b;
        return SAMPLE_W'((wa * wb) >>> FRAC_W);
    endfunction

endpackage

// File: rtl/poly_horner.sv
module poly_horner
    import poly_pkg::*;
(
    input  logic signed [SAMPLE_W-1:0] x,
    input  logic signed [SAMPLE_W-1:0] c0,
    input  logic signed [SAMPLE_W-1:0] c1,
    input  logic signed [SAMPLE_W-1:0] c2,
    input  logic signed [SAMPLE_W-1:0] c3,
    output logic signed [SAMPLE_W-1:0] y
);
    logic signed [SAMPLE_W-1:0] step1;
    logic signed [SAMPLE_W-1:0] step2;

    always_comb begin
        step1 = c2 + qmul(c3, x);
        step2 = c1 + qmul(step1, x);
        y     = c0 + qmul(step2, x);
    end
endmodule

// File: rtl/poly_seq.sv
module poly_seq
    import poly_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [HDR_W-1:0]  hdr_bits,
    input  logic              s_tvalid,
    input  logic              s_tlast,
    output logic              s_tready,
    input  logic [DATA_W-1:0] lane_res,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tvalid,
    output logic              m_tlast,
    input  logic              m_tready,
    output logic              done,
    output logic              halted,
    output logic [7:0]        err_code,
    output logic [15:0]       err_txid
);
    localparam int LANES = DATA_W / SAMPLE_W;

    phase_e      phase_q;
    logic [15:0] txid_q;
    logic [15:0] rem_q;
    cmd_hdr_t    hdr;
    logic        last_beat;
    logic        frame_ok;

    assign hdr       = cmd_hdr_t'(hdr_bits);
    assign last_beat = (rem_q <= 16'(LANES));
    assign frame_ok  = (s_tlast == last_beat);
    assign done      = (phase_q == PH_STOP);

    always_comb begin
        s_tready = 1'b0;
        m_tvalid = 1'b0;
        m_tlast  = 1'b0;
        m_tdata  = '0;
        unique case (phase_q)
            PH_HDR: s_tready = 1'b1;
            PH_RESP: begin
                m_tvalid = 1'b1;
                m_tlast  = (rem_q == 16'd0);
                m_tdata  = DATA_W'({rem_q, txid_q, KIND_DATA});
            end
            PH_BURST: begin
                s_tready = m_tready || !frame_ok;
                m_tvalid = s_tvalid && frame_ok;
                m_tlast  = last_beat;
                for (int i = 0; i < LANES; i++) begin
                    if (i < int'(rem_q))
                        m_tdata[i*SAMPLE_W +: SAMPLE_W] = lane_res[i*SAMPLE_W +: SAMPLE_W];
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            txid_q   <= '0;
            rem_q    <= '0;
            halted   <= 1'b0;
            err_code <= FAULT_NONE;
            err_txid <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE, PH_STOP: begin
                    if (start) begin
                        phase_q  <= PH_HDR;
                        halted   <= 1'b0;
                        err_code <= FAULT_NONE;
                        err_txid <= '0;
                    end
                end
                PH_HDR: begin
                    if (s_tvalid) begin
                        if (!s_tlast) begin
                            phase_q  <= PH_STOP;
                            halted   <= 1'b1;
                            err_code <= FAULT_HDR;
                            err_txid <= hdr.txid;
                        end else if (hdr.kind == KIND_END) begin
                            phase_q <= PH_STOP;
                        end else if (hdr.kind == KIND_DATA) begin
                            phase_q <= PH_RESP;
                            txid_q  <= hdr.txid;
                            rem_q   <= hdr.count;
                        end else begin
                            phase_q  <= PH_STOP;
                            halted   <= 1'b1;
                            err_code <= FAULT_KIND;
                            err_txid <= hdr.txid;
                        end
                    end
                end
                PH_RESP: begin
                    if (m_tready)
                        phase_q <= (rem_q == 16'd0) ? PH_HDR : PH_BURST;
                end
                PH_BURST: begin
                    if (s_tvalid) begin
                        if (!frame_ok) begin
                            phase_q  <= PH_STOP;
                            halted   <= 1'b1;
                            err_code <= FAULT_BURST;
                            err_txid <= txid_q;
                        end else if (m_tready) begin
                            if (last_beat) phase_q <= PH_HDR;
                            else           rem_q   <= rem_q - 16'(LANES);
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/poly_stream_core.sv
module poly_stream_core
    import poly_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [31:0]       coef0,
    input  logic [31:0]       coef1,
    input  logic [31:0]       coef2,
    input  logic [31:0]       coef3,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tvalid,
    input  logic              s_tlast,
    output logic              s_tready,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tvalid,
    output logic              m_tlast,
    input  logic              m_tready,
    output logic              done,
    output logic              halted,
    output logic [7:0]        err_code,
    output logic [15:0]       err_txid
);
    localparam int LANES = DATA_W / SAMPLE_W;

    logic [DATA_W-1:0] lane_res;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        poly_horner lane_i (
            .x  (s_tdata[g*SAMPLE_W +: SAMPLE_W]),
            .c0 (coef0),
            .c1 (coef1),
            .c2 (coef2),
            .c3 (coef3),
            .y  (lane_res[g*SAMPLE_W +: SAMPLE_W])
        );
    end

    poly_seq #(.DATA_W(DATA_W)) seq_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .hdr_bits (s_tdata[HDR_W-1:0]),
        .s_tvalid (s_tvalid),
        .s_tlast  (s_tlast),
        .s_tready (s_tready),
        .lane_res (lane_res),
        .m_tdata  (m_tdata),
        .m_tvalid (m_tvalid),
        .m_tlast  (m_tlast),
        .m_tready (m_tready),
        .done     (done),
        .halted   (halted),
        .err_code (err_code),
        .err_txid (err_txid)
    );
endmodule

// File: rtl/poly_stream_core_chk.sv
module poly_stream_core_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        s_tready,
    input logic        m_tvalid,
    input logic        m_tready,
    input logic        done,
    input logic        halted,
    input logic [7:0]  err_code,
    input logic [15:0] err_txid
);
    // R10
    stop_no_take_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !s_tready);

    // R7
    halt_has_code_chk: assert property (@(posedge clk) disable iff (rst)
        halted |-> (err_code != 8'd0));

    // R2
    clean_end_chk: assert property (@(posedge clk) disable iff (rst)
        (done && err_code == 8'd0) |-> !halted);

    // R10
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(err_code) && $stable(err_txid) && $stable(halted)));

    // R11
    stall_no_take_chk: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |-> !s_tready);

    // R8
    halt_rise_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(halted) |-> done);
endmodule

bind poly_stream_core poly_stream_core_chk chk_i (.*);

// File: tb/poly_stream_core_tb_top.sv
module poly_stream_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] coef0 = '0, coef1 = '0, coef2 = '0, coef3 = '0;
    logic [63:0] s_tdata = '0;
    logic        s_tvalid = 1'b0;
    logic        s_tlast = 1'b0;
    logic        s_tready;
    logic [63:0] m_tdata;
    logic        m_tvalid;
    logic        m_tlast;
    logic        m_tready = 1'b1;
    logic        done;
    logic        halted;
    logic [7:0]  err_code;
    logic [15:0] err_txid;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    poly_stream_core dut_i (
        .clk(clk), .rst(rst), .start(start),
        .coef0(coef0), .coef1(coef1), .coef2(coef2), .coef3(coef3),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tlast(m_tlast), .m_tready(m_tready),
        .done(done), .halted(halted), .err_code(err_code), .err_txid(err_txid)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles == WATCHDOG) begin
            fails++;
            $display("FAIL watchdog: run hung act=%0d exp<%0d cycles", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Reference Horner evaluation in Q16.16 (R4)
    function automatic int ref_poly(input int x);
        int a;
        a = int'(coef3);
        a = int'(coef2) + int'((longint'(a) * longint'(x)) >>> 16);
        a = int'(coef1) + int'((longint'(a) * longint'(x)) >>> 16);
        a = int'(coef0) + int'((longint'(a) * longint'(x)) >>> 16);
        return a;
    endfunction

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_take();
        #1;
        while (!s_tready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
    endtask

    task automatic push_hdr(input logic [7:0] kind, input logic [15:0] id,
                            input logic [15:0] cnt, input logic last);
        s_tdata  = {24'h0, cnt, id, kind};
        s_tlast  = last;
        s_tvalid = 1'b1;
        wait_take();
    endtask

    task automatic check_stop(input string req, input logic h, input logic [7:0] code,
                              input logic [15:0] id);
        #1;
        chk(done == 1'b1, {req, " done"}, 64'(done), 64'd1);
        chk(halted == h, {req, " halted"}, 64'(halted), 64'(h));
        chk(err_code == code, {req, " err_code"}, 64'(err_code), 64'(code));
        chk(err_txid == id, {req, " err_txid"}, 64'(err_txid), 64'(id));
    endtask

    // One DATA command with response and burst; optional backpressure on first beat
    task automatic data_cmd(input logic [15:0] id, input int cnt, input bit bp);
        int beats;
        logic [63:0] exp_resp;
        push_hdr(8'd0, id, 16'(cnt), 1'b1);
        exp_resp = {24'h0, 16'(cnt), id, 8'h00};
        #1;
        chk(m_tvalid && m_tdata == exp_resp, "R3 response word", m_tdata, exp_resp);
        chk(m_tlast == (cnt == 0), "R6 response tlast", 64'(m_tlast), 64'(cnt == 0));
        @(posedge clk);
        @(negedge clk);
        beats = (cnt + 1) / 2;
        for (int b = 0; b < beats; b++) begin
            int x0, x1;
            logic [63:0] exp;
            bit lst;
            x0 = int'($urandom);
            x1 = int'($urandom);
            lst = (b == beats - 1);
            exp[31:0]  = 32'(ref_poly(x0));
            exp[63:32] = (2*b + 1 < cnt) ? 32'(ref_poly(x1)) : 32'h0;
            s_tdata  = {32'(x1), 32'(x0)};
            s_tlast  = lst;
            s_tvalid = 1'b1;
            if (bp && b == 0) begin
                m_tready = 1'b0;
                for (int k = 0; k < 3; k++) begin
                    #1;
                    chk(!s_tready && m_tvalid && m_tdata == exp, "R11 stall holds", m_tdata, exp);
                    @(negedge clk);
                end
                m_tready = 1'b1;
            end
            #1;
            chk(m_tvalid && m_tdata == exp, (2*b + 1 >= cnt) ? "R5 odd lane/result" : "R4 result",
                m_tdata, exp);
            chk(m_tlast == lst, "R5 result tlast", 64'(m_tlast), 64'(lst));
            @(posedge clk);
            @(negedge clk);
            s_tvalid = 1'b0;
            s_tlast  = 1'b0;
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1
        chk(!done && !halted && !s_tready && !m_tvalid, "R1 reset outputs",
            {60'h0, done, halted, s_tready, m_tvalid}, 64'h0);
        chk(err_code == 0 && err_txid == 0, "R1 reset status", {err_code, err_txid}, 64'h0);
        @(negedge clk);

        coef0 = $urandom; coef1 = $urandom; coef2 = $urandom; coef3 = $urandom;
        pulse_start();
        #1;
        chk(!done && s_tready, "R10 start opens header intake", {done, s_tready}, 64'h1);
        @(negedge clk);
        data_cmd(16'h1111, 4, 1'b0);
        data_cmd(16'h2222, 3, 1'b0);
        data_cmd(16'h3333, 1, 1'b1);
        data_cmd(16'h4444, 0, 1'b0);   // R6
        for (int n = 0; n < 12; n++)   // R12 back-to-back commands
            data_cmd(16'($urandom), int'($urandom_range(0, 9)), ($urandom_range(0, 3) == 0));
        coef0 = 32'h0001_0000; coef1 = 32'hFFFF_0000; coef2 = 32'h0000_8000; coef3 = 32'h0;
        data_cmd(16'h5555, 2, 1'b0);
        push_hdr(8'd1, 16'h0EEE, 16'd0, 1'b1);
        check_stop("R2 END clean", 1'b0, 8'd0, 16'd0);

        // R7 header without TLAST
        pulse_start();
        push_hdr(8'd0, 16'hABCD, 16'd4, 1'b0);
        check_stop("R7 header framing", 1'b1, 8'd1, 16'hABCD);
        s_tdata = 64'h1; s_tlast = 1'b1; s_tvalid = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #1;
            chk(!s_tready && !m_tvalid, "R10 no intake while stopped", 64'(s_tready), 64'h0);
        end
        check_stop("R10 status held", 1'b1, 8'd1, 16'hABCD);
        s_tvalid = 1'b0; s_tlast = 1'b0;
        @(negedge clk);

        // R8 early TLAST
        pulse_start();
        #1;
        chk(!halted && err_code == 0 && err_txid == 0, "R10 start clears status",
            {halted, err_code, err_txid}, 64'h0);
        @(negedge clk);
        push_hdr(8'd0, 16'h0BAD, 16'd4, 1'b1);
        @(posedge clk);
        @(negedge clk);
        s_tdata = 64'h5; s_tlast = 1'b1; s_tvalid = 1'b1;
        #1;
        chk(!m_tvalid && s_tready, "R8 early beat emits nothing", 64'(m_tvalid), 64'h0);
        @(posedge clk);
        @(negedge clk);
        s_tvalid = 1'b0; s_tlast = 1'b0;
        check_stop("R8 early tlast", 1'b1, 8'd2, 16'h0BAD);

        // R8 late TLAST
        pulse_start();
        push_hdr(8'd0, 16'h7A7E, 16'd3, 1'b1);
        @(posedge clk);
        @(negedge clk);
        s_tdata = 64'h0; s_tlast = 1'b0; s_tvalid = 1'b1;
        #1;
        chk(m_tvalid && !m_tlast, "R8 first beat fine", 64'(m_tlast), 64'h0);
        @(posedge clk);
        @(negedge clk);
        s_tlast = 1'b0;
        #1;
        chk(!m_tvalid, "R8 late beat emits nothing", 64'(m_tvalid), 64'h0);
        @(posedge clk);
        @(negedge clk);
        s_tvalid = 1'b0;
        check_stop("R8 late tlast", 1'b1, 8'd2, 16'h7A7E);

        // R9 unknown kind
        pulse_start();
        push_hdr(8'd5, 16'h0C0C, 16'd2, 1'b1);
        check_stop("R9 unknown kind", 1'b1, 8'd3, 16'h0C0C);

        // R10 restart then clean END
        pulse_start();
        push_hdr(8'd1, 16'h0001, 16'd0, 1'b1);
        check_stop("R10 restart clean", 1'b0, 8'd0, 16'd0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule